// File: doc/BRIEF.md
# Ethernet PHY Bring-up Sequencer

This block brings an Ethernet PHY to a negotiated link after reset. It works through a fixed series of management register accesses. Each access goes out through a request/acknowledge port to an MDIO master that sits next to it. The sequence is:

1. Soft-reset the PHY and poll until the reset bit clears.
2. Mask every PHY interrupt source.
3. Read the capability bits from the status register and build an advertisement word from them, then write it.
4. Restart autonegotiation and poll until it completes.

A millisecond tick input sets the spacing between polls. Both polling loops have a retry limit. A remote fault seen during negotiation triggers one restart with speed and duplex forced.

The block starts on its own once reset is released. It finishes in one of two terminal states. One raises `done`. The other raises `fail` together with a two-bit reason code.

Only one management transaction is outstanding at any time. The sequencer holds its request until it sees the acknowledge, and for reads it takes the read data in that same cycle.

Top module: `phy_bringup_seq`

## Requirements
- R1: The first transaction after reset is a write to register 0 with data 0x8000: bit 15 (reset) set, all other bits zero.
- R2: The reset-completion loop reads register 0. Between the acknowledge of one such read and the request of the next, exactly POLL_MS ticks are counted.
- R3: If RST_POLLS consecutive reads of register 0 return bit 15 set, the block ends with `fail`=1 and `err_code`=01 and issues no further request.
- R4: Once a read of register 0 returns bit 15 clear, the block writes 0xFFFF to register 18 and then reads register 1.
- R5: The advertisement word is written to register 4. Bit 0 is always set. Bits 9, 8, 7, 6 and 5 copy status bits 15, 14, 13, 12 and 11 of the register 1 read. All other bits are zero.
- R6: After the advertisement write, register 0 is written with 0x1200 (bit 12 negotiation enable, bit 9 restart).
- R7: Negotiation polling reads register 1, spaced exactly POLL_MS ticks apart. A read with bit 5 set and bit 4 clear ends the block with `done`=1 and `err_code`=00.
- R8: A poll read with bit 5 clear and bit 4 (remote fault) set, when it is not the last allowed poll, is followed after the poll interval by a write of 0x3300 to register 0 (bits 13, 12, 9, 8). Polling of register 1 then resumes.
- R9: If AN_POLLS reads of register 1 all have bit 5 clear and the last one has bit 4 clear, the block ends with `fail`=1 and `err_code`=10.
- R10: If the read that ends negotiation polling has bit 4 set, whether it completed or was the last allowed poll, the block ends with `fail`=1 and `err_code`=11.
- R11: While a request is raised and not yet acknowledged, the write flag, register number and write data stay unchanged.
- R12: `done` and `fail` are never both high, and each stays high once set. `err_code` is 00 whenever `fail` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| mgmt_req | output | 1 | Management transaction request |
| mgmt_wr | output | 1 | 1 = write, 0 = read |
| mgmt_reg | output | 5 | PHY register number |
| mgmt_wdata | output | 16 | Write data |
| mgmt_ack | input | 1 | Transaction complete, one cycle |
| mgmt_rdata | input | 16 | Read data, valid with mgmt_ack |
| done | output | 1 | Bring-up succeeded |
| fail | output | 1 | Bring-up failed |
| err_code | output | 2 | 00 none, 01 reset timeout, 10 negotiation timeout, 11 remote fault |

## Verification
The hardest case to reach is a remote fault on the very last allowed negotiation poll. That read must end the run with code 11, not with a timeout and not with another forced restart. The bench reaches it by feeding nineteen incomplete status words and then one with only the fault bit set, and it expects no further transaction after that read.

The exact poll spacing is also hard to see from the ports. It is checked by counting tick pulses from each read acknowledge to the next read request of the same register.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RST_WR, ST_RST_RD, ST_RST_WAIT, ST_MASK_WR, ST_CAP_RD,
        ST_ADV_WR, ST_AN_WR, ST_AN_RD, ST_AN_WAIT, ST_FRC_WR, ST_DONE, ST_FAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_RST_TMO = 2'd1,
        ERR_AN_TMO  = 2'd2,
        ERR_REM_FLT = 2'd3
    } seq_err_e;

    localparam logic [4:0]  REG_CTRL  = 5'd0;
    localparam logic [4:0]  REG_STAT  = 5'd1;
    localparam logic [4:0]  REG_ADV   = 5'd4;
    localparam logic [4:0]  REG_IMASK = 5'd18;

    localparam logic [15:0] CTRL_RESET      = 16'h8000;
    localparam logic [15:0] CTRL_AN_RESTART = 16'h1200;
    localparam logic [15:0] CTRL_AN_FORCED  = 16'h3300;
    localparam logic [15:0] IMASK_ALL       = 16'hFFFF;
    localparam logic [15:0] ADV_SELECTOR    = 16'h0001;

    localparam int CTRL_RESET_BIT = 15;
    localparam int STAT_AN_DONE   = 5;
    localparam int STAT_REM_FLT   = 4;
    localparam int STAT_CAP_LO    = 11;
    localparam int ADV_CAP_LO     = 5;
    localparam int NUM_CAPS       = 5;

endpackage

// File: rtl/phy_adv_builder.sv
module phy_adv_builder
    import phy_bringup_pkg::*;
(
    input  logic [NUM_CAPS-1:0] caps,
    output logic [15:0]         adv_word
);
    logic [15:0] cap_field;

    generate
        for (genvar i = 0; i < 16; i++) begin : g_bit
            if (i >= ADV_CAP_LO && i < ADV_CAP_LO + NUM_CAPS) begin : g_cap
                assign cap_field[i] = caps[i - ADV_CAP_LO];
            end else begin : g_zero
                assign cap_field[i] = 1'b0;
            end
        end
    endgenerate

    assign adv_word = cap_field | ADV_SELECTOR;

endmodule

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
    parameter int POLL_MS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = (POLL_MS < 2) ? 1 : $clog2(POLL_MS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == CNT_W'(POLL_MS - 1)) begin
                expire = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(POLL_MS - 1));

    a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_bringup_pkg::*;
#(
    parameter int POLL_MS   = 500,
    parameter int RST_POLLS = 6,
    parameter int AN_POLLS  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ms_tick,
    output logic        mgmt_req,
    output logic        mgmt_wr,
    output logic [4:0]  mgmt_reg,
    output logic [15:0] mgmt_wdata,
    input  logic        mgmt_ack,
    input  logic [15:0] mgmt_rdata,
    output logic        done,
    output logic        fail,
    output logic [1:0]  err_code
);
    localparam int MAX_POLLS = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
    localparam int PW        = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        seq_state_e  st;
        logic [PW-1:0] poll;
        logic        fault;
        logic [15:0] adv;
        seq_err_e    err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      tmr_run, tmr_expire;
    logic [15:0] adv_built;

    phy_adv_builder u_adv (
        .caps     (mgmt_rdata[STAT_CAP_LO +: NUM_CAPS]),
        .adv_word (adv_built)
    );

    assign tmr_run = (r_q.st == ST_RST_WAIT) || (r_q.st == ST_AN_WAIT);

    phy_poll_timer #(.POLL_MS(POLL_MS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .tick   (ms_tick),
        .expire (tmr_expire)
    );

    // request decode from the registered state
    always_comb begin
        mgmt_req   = 1'b1;
        mgmt_wr    = 1'b0;
        mgmt_reg   = REG_CTRL;
        mgmt_wdata = '0;
        unique case (r_q.st)
            ST_RST_WR:  begin mgmt_wr = 1'b1; mgmt_wdata = CTRL_RESET; end
            ST_RST_RD:  ;
            ST_MASK_WR: begin mgmt_wr = 1'b1; mgmt_reg = REG_IMASK; mgmt_wdata = IMASK_ALL; end
            ST_CAP_RD:  mgmt_reg = REG_STAT;
            ST_ADV_WR:  begin mgmt_wr = 1'b1; mgmt_reg = REG_ADV; mgmt_wdata = r_q.adv; end
            ST_AN_WR:   begin mgmt_wr = 1'b1; mgmt_wdata = CTRL_AN_RESTART; end
            ST_AN_RD:   mgmt_reg = REG_STAT;
            ST_FRC_WR:  begin mgmt_wr = 1'b1; mgmt_wdata = CTRL_AN_FORCED; end
            default:    mgmt_req = 1'b0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: r_d.st = ST_RST_WR;
            ST_RST_WR: if (mgmt_ack) begin
                r_d.st   = ST_RST_RD;
                r_d.poll = '0;
            end
            ST_RST_RD: if (mgmt_ack) begin
                if (!mgmt_rdata[CTRL_RESET_BIT]) begin
                    r_d.st = ST_MASK_WR;
                end else if (r_q.poll == PW'(RST_POLLS - 1)) begin
                    r_d.st  = ST_FAIL;
                    r_d.err = ERR_RST_TMO;
                end else begin
                    r_d.poll = r_q.poll + 1'b1;
                    r_d.st   = ST_RST_WAIT;
                end
            end
            ST_RST_WAIT: if (tmr_expire) r_d.st = ST_RST_RD;
            ST_MASK_WR:  if (mgmt_ack) r_d.st = ST_CAP_RD;
            ST_CAP_RD: if (mgmt_ack) begin
                r_d.adv = adv_built;
                r_d.st  = ST_ADV_WR;
            end
            ST_ADV_WR: if (mgmt_ack) r_d.st = ST_AN_WR;
            ST_AN_WR: if (mgmt_ack) begin
                r_d.st   = ST_AN_RD;
                r_d.poll = '0;
            end
            ST_AN_RD: if (mgmt_ack) begin
                r_d.fault = mgmt_rdata[STAT_REM_FLT];
                if (mgmt_rdata[STAT_AN_DONE]) begin
                    if (mgmt_rdata[STAT_REM_FLT]) begin
                        r_d.st  = ST_FAIL;
                        r_d.err = ERR_REM_FLT;
                    end else begin
                        r_d.st = ST_DONE;
                    end
                end else if (r_q.poll == PW'(AN_POLLS - 1)) begin
                    r_d.st  = ST_FAIL;
                    r_d.err = mgmt_rdata[STAT_REM_FLT] ? ERR_REM_FLT : ERR_AN_TMO;
                end else begin
                    r_d.poll = r_q.poll + 1'b1;
                    r_d.st   = ST_AN_WAIT;
                end
            end
            ST_AN_WAIT: if (tmr_expire) r_d.st = r_q.fault ? ST_FRC_WR : ST_AN_RD;
            ST_FRC_WR:  if (mgmt_ack) r_d.st = ST_AN_RD;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.poll  <= '0;
            r_q.fault <= 1'b0;
            r_q.adv   <= '0;
            r_q.err   <= ERR_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = (r_q.st == ST_DONE);
    assign fail     = (r_q.st == ST_FAIL);
    assign err_code = r_q.err;

    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_wr) &&
                                     $stable(mgmt_reg) && $stable(mgmt_wdata)));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r12_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (fail && $stable(err_code)));

    a_r12_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fail |-> err_code == 2'd0);

    a_r3_no_req_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !mgmt_req);

    a_r5_adv_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && mgmt_wr && mgmt_reg == REG_ADV) |->
        (mgmt_wdata[0] && mgmt_wdata[15:10] == 6'd0 && mgmt_wdata[4:1] == 4'd0));

endmodule

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int POLL_MS    = 3;
    localparam int RST_POLLS  = 6;
    localparam int AN_POLLS   = 20;

    typedef struct packed {
        logic        wr;
        logic [4:0]  rg;
        logic [15:0] data;
    } txn_t;

    logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
    logic mgmt_req, mgmt_wr, mgmt_ack = 1'b0;
    logic [4:0] mgmt_reg;
    logic [15:0] mgmt_wdata, mgmt_rdata = '0;
    logic done, fail;
    logic [1:0] err_code;

    int n_tests = 0, n_fail = 0;
    txn_t  exp_q[$];
    string tag_q[$];
    logic [15:0] rsp_q[$];

    phy_bringup_seq #(.POLL_MS(POLL_MS), .RST_POLLS(RST_POLLS), .AN_POLLS(AN_POLLS))
    i_phy_bringup_seq (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .mgmt_req(mgmt_req), .mgmt_wr(mgmt_wr), .mgmt_reg(mgmt_reg),
        .mgmt_wdata(mgmt_wdata), .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata),
        .done(done), .fail(fail), .err_code(err_code)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(posedge clk); #1 ms_tick = ~ms_tick;
    end

    task automatic check(input bit ok, input string tag, input string got, input string exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", tag, got, exp);
        end
    endtask

    task automatic push_wr(input logic [4:0] rg, input logic [15:0] d, input string tag);
        exp_q.push_back('{wr: 1'b1, rg: rg, data: d});
        tag_q.push_back(tag);
    endtask

    task automatic push_rd(input logic [4:0] rg, input logic [15:0] rsp, input string tag);
        exp_q.push_back('{wr: 1'b0, rg: rg, data: 16'h0});
        tag_q.push_back(tag);
        rsp_q.push_back(rsp);
    endtask

    // monitor and PHY responder: every change lands 1 time unit after a rising edge
    initial begin
        bit busy = 0;
        int lat = 0;
        int ticks = 0;
        int prev_rd = -1;
        logic cur_wr = 0;
        logic [4:0] cur_rg = 0;
        logic nxt_ack;
        logic [15:0] nxt_data;
        forever begin
            @(negedge clk);
            nxt_ack = 1'b0;
            nxt_data = 16'h0;
            if (!rst_n) begin
                busy = 0; ticks = 0; prev_rd = -1;
            end else if (mgmt_ack) begin
                ticks = 0;
                busy = 0;
                prev_rd = cur_wr ? -1 : int'(cur_rg);
            end else if (mgmt_req && !busy) begin
                txn_t got, exp;
                string tag;
                got = '{wr: mgmt_wr, rg: mgmt_reg, data: mgmt_wr ? mgmt_wdata : 16'h0};
                if (exp_q.size() == 0) begin
                    check(0, "R3", $sformatf("txn %h", got), "no transaction");
                end else begin
                    exp = exp_q.pop_front();
                    tag = tag_q.pop_front();
                    check(got == exp, tag, $sformatf("%h", got), $sformatf("%h", exp));
                end
                if (!mgmt_wr && prev_rd == int'(mgmt_reg))
                    check(ticks == POLL_MS, (mgmt_reg == 5'd0) ? "R2" : "R7",
                          $sformatf("%0d ticks", ticks), $sformatf("%0d ticks", POLL_MS));
                cur_wr = mgmt_wr;
                cur_rg = mgmt_reg;
                busy = 1;
                lat = 2;
            end else if (busy) begin
                lat--;
                if (lat == 0) begin
                    nxt_ack = 1'b1;
                    if (!cur_wr && rsp_q.size() != 0) nxt_data = rsp_q.pop_front();
                end
            end else if (ms_tick) begin
                ticks++;
            end
            @(posedge clk);
            #1;
            mgmt_ack = nxt_ack;
            mgmt_rdata = nxt_data;
        end
    end

    int cyc = 0;
    initial forever begin
        @(posedge clk);
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        exp_q.delete(); tag_q.delete(); rsp_q.delete();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!mgmt_req && !done && !fail && err_code == 2'd0, "R12",
              $sformatf("req%b done%b fail%b err%0d", mgmt_req, done, fail, err_code),
              "all zero in reset");
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic finish_run(input bit e_done, input bit e_fail, input logic [1:0] e_err,
                              input string tag);
        int w = 0;
        while (!(done || fail) && w < 5000) begin
            @(negedge clk); w++;
        end
        repeat (12) @(negedge clk);
        check(done == e_done && fail == e_fail && err_code == e_err, tag,
              $sformatf("done%b fail%b err%0d", done, fail, err_code),
              $sformatf("done%b fail%b err%0d", e_done, e_fail, e_err));
        check(exp_q.size() == 0 && !mgmt_req, tag,
              $sformatf("%0d pending", exp_q.size()), "0 pending");
    endtask

    task automatic reset_ok_prefix(input int busy_reads);
        push_wr(5'd0, 16'h8000, "R1");
        for (int i = 0; i < busy_reads; i++) push_rd(5'd0, 16'h9140, "R2");
        push_rd(5'd0, 16'h1140, "R2");
        push_wr(5'd18, 16'hFFFF, "R4");
    endtask

    initial begin
        // normal bring-up, all but T4 capable
        do_reset();
        reset_ok_prefix(2);
        push_rd(5'd1, 16'h7849, "R4");
        push_wr(5'd4, 16'h01E1, "R5");
        push_wr(5'd0, 16'h1200, "R6");
        push_rd(5'd1, 16'h7809, "R7");
        push_rd(5'd1, 16'h782D, "R7");
        finish_run(1'b1, 1'b0, 2'd0, "R7");

        // reset never completes
        do_reset();
        push_wr(5'd0, 16'h8000, "R1");
        for (int i = 0; i < RST_POLLS; i++) push_rd(5'd0, 16'h8000, "R3");
        finish_run(1'b0, 1'b1, 2'd1, "R3");

        // T4 and 10HD with noise bits, remote fault then forced restart
        do_reset();
        reset_ok_prefix(0);
        push_rd(5'd1, 16'h8A3F, "R5");
        push_wr(5'd4, 16'h0221, "R5");
        push_wr(5'd0, 16'h1200, "R6");
        push_rd(5'd1, 16'h0010, "R8");
        push_wr(5'd0, 16'h3300, "R8");
        push_rd(5'd1, 16'h0020, "R8");
        finish_run(1'b1, 1'b0, 2'd0, "R8");

        // negotiation never completes
        do_reset();
        reset_ok_prefix(1);
        push_rd(5'd1, 16'h0000, "R5");
        push_wr(5'd4, 16'h0001, "R5");
        push_wr(5'd0, 16'h1200, "R6");
        for (int i = 0; i < AN_POLLS; i++) push_rd(5'd1, 16'h0000, "R9");
        finish_run(1'b0, 1'b1, 2'd2, "R9");

        // completion reported together with remote fault
        do_reset();
        reset_ok_prefix(0);
        push_rd(5'd1, 16'hF800, "R5");
        push_wr(5'd4, 16'h03E1, "R5");
        push_wr(5'd0, 16'h1200, "R6");
        push_rd(5'd1, 16'h0030, "R10");
        finish_run(1'b0, 1'b1, 2'd3, "R10");

        // fault on the last allowed poll: no forced restart, fault code
        do_reset();
        reset_ok_prefix(0);
        push_rd(5'd1, 16'h4000, "R5");
        push_wr(5'd4, 16'h0101, "R5");
        push_wr(5'd0, 16'h1200, "R6");
        for (int i = 0; i < AN_POLLS - 1; i++) push_rd(5'd1, 16'h0000, "R9");
        push_rd(5'd1, 16'h0010, "R10");
        finish_run(1'b0, 1'b1, 2'd3, "R10");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule